// File: doc/BRIEF.md
# Four-Phase Daisy-Chain Data Merger

This block is one node of a readout chain in which neighbouring nodes move words using a four-phase bundled-data handshake. In each transfer the request rises, then the acknowledge rises, then the request falls, and last the acknowledge falls. The node has two input sources. The first is the upstream neighbour, which forwards the traffic of the whole chain behind this node. The second is the local column buffer, which presents its own words on a second request/acknowledge pair. The node merges both sources onto one downstream request/acknowledge port, working as a 2-to-1 time-division multiplexer. It needs no control signal other than the handshake wires.

The block is a synchronous model. Each incoming handshake wire (both source requests and the downstream acknowledge) passes through a synchronizer of `SYNC_STAGES` flops. The node then accepts a pending source and latches that source's word into an output register, tagged with a 1-bit origin flag. It holds the word one full cycle before it raises the downstream request. It completes the whole downstream four-phase cycle first, and only then acknowledges the source. When both sources are waiting, the node serves them in turn.

The controller has five states. IDLE goes to SETUP when some source is pending (the word is latched and the arbiter's choice is recorded). SETUP always goes to REQ. REQ goes to RETURN once the synchronized downstream acknowledge is high. RETURN goes to GRANT once that acknowledge is low again. GRANT goes to IDLE once the synchronized request of the served source has fallen.

Top module: `daisy_merge`

## Requirements
- R1: While reset is held low, `dn_req`, `up_ack` and `loc_ack` are all low.
- R2: `dn_data` already holds its final value in the cycle before `dn_req` rises, and it does not change while `dn_req` is high.
- R3: `dn_req` falls only after `dn_ack` has been seen high, and it stays high until then.
- R4: A source acknowledge (`up_ack` or `loc_ack`) rises only when `dn_req` and `dn_ack` are both low, which means the downstream cycle for that word has finished.
- R5: At most one of `up_ack` and `loc_ack` is high at any time. A source acknowledge stays high for as long as that source keeps its request high, and it falls after the request has fallen.
- R6: `dn_data[DATA_W]` is the origin flag: 0 means the word came from upstream and 1 means it came from the local source. `dn_data[DATA_W-1:0]` equals the source word without change.
- R7: If both sources are pending together, the node serves the one it did not serve last. After reset, upstream counts as not served last, so upstream goes first. Two sources that stay busy therefore alternate as upstream, local, upstream, and so on.
- R8: The words from each source leave downstream in the order that source offered them, and each word appears exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low reset |
| up_req | input | 1 | Request from the upstream neighbour |
| up_data | input | DATA_W | Word from the upstream neighbour |
| up_ack | output | 1 | Acknowledge to the upstream neighbour |
| loc_req | input | 1 | Request from the local column buffer |
| loc_data | input | DATA_W | Word from the local column buffer |
| loc_ack | output | 1 | Acknowledge to the local column buffer |
| dn_req | output | 1 | Request to the downstream neighbour |
| dn_data | output | DATA_W+1 | Origin flag (MSB) and payload to downstream |
| dn_ack | input | 1 | Acknowledge from the downstream neighbour |

## Verification
The bench builds the node with `DATA_W = 12` and `SYNC_STAGES = 3`. This exercises the deeper synchronizer branch and makes every handshake phase last several cycles, so a source can re-request while the other source is in mid-transfer. The 12-bit payload leaves room for distinct value ranges per source and per phase, and the flag then sits at bit 12. A directed phase starts both sources in the same cycle to check the first-served choice and the alternation. A random phase, with random source gaps, acknowledge holds and downstream delays, checks ordering, tagging and handshake order.

// File: rtl/merge_pkg.sv
package merge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_REQ    = 3'd2,
        ST_RETURN = 3'd3,
        ST_GRANT  = 3'd4
    } merge_state_t;

    typedef enum logic {
        SRC_UP  = 1'b0,
        SRC_LOC = 1'b1
    } merge_src_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rr_pick.sv
module rr_pick
    import merge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend_up,
    input  logic       pend_loc,
    input  logic       take,
    output logic       any,
    output merge_src_t pick
);
    merge_src_t last_q;

    always_comb begin
        any = pend_up | pend_loc;
        if (pend_up && pend_loc)
            pick = (last_q == SRC_UP) ? SRC_LOC : SRC_UP;
        else if (pend_loc)
            pick = SRC_LOC;
        else
            pick = SRC_UP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              last_q <= SRC_LOC;
        else if (take && any)    last_q <= pick;
    end
endmodule

// File: rtl/word_latch.sv
module word_latch
    import merge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  merge_src_t        src,
    input  logic [DATA_W-1:0] up_word,
    input  logic [DATA_W-1:0] loc_word,
    output logic [DATA_W:0]   word_q
);
    logic [DATA_W-1:0] payload;

    assign payload = (src == SRC_LOC) ? loc_word : up_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= {src == SRC_LOC, payload};
    end
endmodule

// File: rtl/daisy_merge.sv
module daisy_merge
    import merge_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ack,
    input  logic              loc_req,
    input  logic [DATA_W-1:0] loc_data,
    output logic              loc_ack,
    output logic              dn_req,
    output logic [DATA_W:0]   dn_data,
    input  logic              dn_ack
);
    localparam int WORD_W = DATA_W + 1;

    logic up_req_s, loc_req_s, dn_ack_s;
    logic any_pend, take;
    merge_src_t pick, sel_q;
    merge_state_t state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic sel_req_s;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_up  (.clk(clk), .rst_n(rst_n), .d(up_req),  .q(up_req_s));
    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_loc (.clk(clk), .rst_n(rst_n), .d(loc_req), .q(loc_req_s));
    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_dn  (.clk(clk), .rst_n(rst_n), .d(dn_ack),  .q(dn_ack_s));

    assign take = (state_q == ST_IDLE) && any_pend;

    rr_pick u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_up  (up_req_s),
        .pend_loc (loc_req_s),
        .take     (take),
        .any      (any_pend),
        .pick     (pick)
    );

    word_latch #(.DATA_W(DATA_W)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .src      (pick),
        .up_word  (up_data),
        .loc_word (loc_data),
        .word_q   (word_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sel_q <= SRC_UP;
        else if (take) sel_q <= pick;
    end

    assign sel_req_s = (sel_q == SRC_LOC) ? loc_req_s : up_req_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_pend)   state_d = ST_SETUP;
            ST_SETUP:                  state_d = ST_REQ;
            ST_REQ:    if (dn_ack_s)   state_d = ST_RETURN;
            ST_RETURN: if (!dn_ack_s)  state_d = ST_GRANT;
            ST_GRANT:  if (!sel_req_s) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dn_req  = 1'b0;
        up_ack  = 1'b0;
        loc_ack = 1'b0;
        unique case (state_q)
            ST_REQ:   dn_req = 1'b1;
            ST_GRANT: begin
                up_ack  = (sel_q == SRC_UP);
                loc_ack = (sel_q == SRC_LOC);
            end
            default: ;
        endcase
    end

    assign dn_data = word_q;

endmodule

// File: rtl/daisy_merge_chk.sv
module daisy_merge_chk #(
    parameter int DATA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            up_req,
    input logic            up_ack,
    input logic            loc_req,
    input logic            loc_ack,
    input logic            dn_req,
    input logic [DATA_W:0] dn_data,
    input logic            dn_ack
);
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && $past(dn_req)) |-> $stable(dn_data)); // R2
    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) |-> $stable(dn_data)); // R2
    AST_REQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_req) |-> $past(dn_ack)); // R3
    AST_UP_ACK_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> (!dn_req && !dn_ack)); // R4
    AST_LOC_ACK_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_ack) |-> (!dn_req && !dn_ack)); // R4
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_ack, loc_ack})); // R5
    AST_UP_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_ack && up_req) |=> up_ack); // R5
    AST_LOC_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ack && loc_req) |=> loc_ack); // R5
endmodule

bind daisy_merge daisy_merge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_req  (up_req),
    .up_ack  (up_ack),
    .loc_req (loc_req),
    .loc_ack (loc_ack),
    .dn_req  (dn_req),
    .dn_data (dn_data),
    .dn_ack  (dn_ack)
);

// File: tb/daisy_merge_tb.sv
module daisy_merge_tb;
    localparam int DW = 12;
    localparam int SS = 3;
    localparam int NA = 4;
    localparam int NB = 30;
    localparam int NTOT = 2 * (NA + NB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_req = 1'b0, loc_req = 1'b0, dn_ack = 1'b0;
    logic [DW-1:0] up_data = '0, loc_data = '0;
    logic up_ack, loc_ack, dn_req;
    logic [DW:0] dn_data;

    int n_chk = 0, n_fail = 0, n_rx = 0;
    int n_up_sent = 0, n_loc_sent = 0;
    logic [DW:0]   prev_data = '0;
    logic          rx_flag [0:127];
    logic [DW-1:0] rx_pay  [0:127];
    logic [DW-1:0] up_sent [0:63];
    logic [DW-1:0] loc_sent[0:63];
    bit done = 0;
    int unsigned seed_tmp;

    always #5 clk = ~clk;

    daisy_merge #(.DATA_W(DW), .SYNC_STAGES(SS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_data(up_data), .up_ack(up_ack),
        .loc_req(loc_req), .loc_data(loc_data), .loc_ack(loc_ack),
        .dn_req(dn_req), .dn_data(dn_data), .dn_ack(dn_ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] up_word(input int ph, input int i);
        return (ph == 0) ? DW'(12'h100 + i) : DW'(12'h200 + i);
    endfunction

    function automatic logic [DW-1:0] loc_word(input int ph, input int i);
        return (ph == 0) ? DW'(12'h800 + i) : DW'(12'hA00 + i);
    endfunction

    task automatic send_up(input logic [DW-1:0] w, input int gap);
        repeat (gap) @(negedge clk);
        up_sent[n_up_sent] = w;
        n_up_sent++;
        up_data = w;
        @(negedge clk);
        up_req = 1'b1;
        do @(negedge clk); while (!up_ack);
        check(!dn_req && !dn_ack, "R4 up ack before downstream done", {dn_req, dn_ack}, 0);
        check(!loc_ack, "R5 both acks high (up)", loc_ack, 0);
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            check(up_ack, "R5 up ack dropped early", up_ack, 1);
        end
        up_req = 1'b0;
        do @(negedge clk); while (up_ack);
    endtask

    task automatic send_loc(input logic [DW-1:0] w, input int gap);
        repeat (gap) @(negedge clk);
        loc_sent[n_loc_sent] = w;
        n_loc_sent++;
        loc_data = w;
        @(negedge clk);
        loc_req = 1'b1;
        do @(negedge clk); while (!loc_ack);
        check(!dn_req && !dn_ack, "R4 loc ack before downstream done", {dn_req, dn_ack}, 0);
        check(!up_ack, "R5 both acks high (loc)", up_ack, 0);
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            check(loc_ack, "R5 loc ack dropped early", loc_ack, 1);
        end
        loc_req = 1'b0;
        do @(negedge clk); while (loc_ack);
    endtask

    // downstream responder
    initial begin
        logic [DW:0] first;
        forever begin
            @(negedge clk);
            if (rst_n && dn_req) begin
                first = dn_data;
                check(prev_data == dn_data, "R2 data not set before request", int'(dn_data), int'(prev_data));
                repeat ($urandom_range(0, 4)) begin
                    @(negedge clk);
                    check(dn_req, "R3 request fell before ack", dn_req, 1);
                end
                check(dn_data == first, "R2 data moved during request", int'(dn_data), int'(first));
                if (n_rx < 128) begin
                    rx_flag[n_rx] = dn_data[DW];
                    rx_pay[n_rx]  = dn_data[DW-1:0];
                end
                n_rx++;
                dn_ack = 1'b1;
                do @(negedge clk); while (dn_req);
                repeat ($urandom_range(0, 4)) @(negedge clk);
                dn_ack = 1'b0;
            end
            prev_data = dn_data;
        end
    end

    task automatic wait_rx(input int target);
        while (n_rx < target) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        seed_tmp = $urandom(32'd52817);
        repeat (5) @(negedge clk);
        check(!dn_req, "R1 dn_req in reset", dn_req, 0);
        check(!up_ack, "R1 up_ack in reset", up_ack, 0);
        check(!loc_ack, "R1 loc_ack in reset", loc_ack, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // directed: both sources start together and stay busy
        fork
            for (int i = 0; i < NA; i++) send_up(up_word(0, i), 0);
            for (int i = 0; i < NA; i++) send_loc(loc_word(0, i), 0);
        join
        wait_rx(2 * NA);
        for (int k = 0; k < 2 * NA; k++)
            check(rx_flag[k] == k[0], "R7 alternation order", int'(rx_flag[k]), k % 2);

        // random phase
        fork
            for (int i = 0; i < NB; i++) send_up(up_word(1, i), int'($urandom_range(0, 12)));
            for (int i = 0; i < NB; i++) send_loc(loc_word(1, i), int'($urandom_range(0, 12)));
        join
        wait_rx(NTOT);

        check(n_rx == NTOT, "R8 word count", n_rx, NTOT);
        begin
            int ui = 0;
            int li = 0;
            for (int k = 0; k < NTOT && k < 128; k++) begin
                if (rx_flag[k] == 1'b0) begin
                    check(ui < n_up_sent && rx_pay[k] == up_sent[ui],
                          "R6 R8 upstream payload/order", int'(rx_pay[k]), int'(up_sent[ui]));
                    ui++;
                end else begin
                    check(li < n_loc_sent && rx_pay[k] == loc_sent[li],
                          "R6 R8 local payload/order", int'(rx_pay[k]), int'(loc_sent[li]));
                    li++;
                end
            end
            check(ui == NA + NB, "R6 upstream flag count", ui, NA + NB);
            check(li == NA + NB, "R6 local flag count", li, NA + NB);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", n_rx, NTOT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule